// File: doc/BRIEF.md
# Key Derivation Stage Controller

This block is the control core of a staged key-derivation engine. It holds the current key stage, climbs a fixed ladder of stages on command, and runs the key-producing operations for the stage it is in. The arithmetic of derivation is done by an external hash engine. This controller only asks for that work through a request/done handshake and judges the data that comes back.

Software programs a 3-bit operation code and a key version, then writes the start word. While the operation runs, the configuration-enable output is low. Writes to the three per-stage version limits are held off during that time. When the operation ends, the block reports its outcome in a 2-bit status and pulses an operation-done strobe. Operations that are not allowed, and key versions above the limit for the current stage, set a sticky error flag. Hash data that comes back as all zeros or all ones is a fatal fault and drops the engine into its terminal invalid stage.

There are two terminal stages, disabled and invalid, and only reset leaves them. A lockable software-binding write enable is unlocked again only by an advance that actually climbs a stage.

Top module: `kdf_stage_ctrl`

## Requirements
- R1: After reset, work_state is 0 (Reset), op_status is 0, cfg_en and sw_bind_en are 1, and err_invalid_op, fault_hash, op_done and hash_req are 0. After INIT_CYCLES cycles of Reset with no operation in flight, work_state becomes 1 (Init).
- R2: An operation starts only when start_we is high, start_data equals exactly 1 and cfg_en is 1. Any other start_data value has no effect. The cycle after a start, op_status reads 1 (busy) and cfg_en reads 0.
- R3: cfg_en stays 0 from the cycle after a start until the operation completes. Limit writes (lim_we) made while cfg_en is 0 are ignored.
- R4: Operation codes are 0 advance, 1 generate ID, 2 generate software output, 3 generate hardware output and 4 disable. In stages 1 to 3, an advance raises hash_req and holds it until hash_done. It then moves work_state up by one (1→2→3→4) with op_status 2 (done success). Generate operations also use the hash handshake and leave the stage unchanged.
- R5: An advance issued in stage 4 (Owner Key) acts as a disable. It moves to stage 5 (Disabled) without a hash request and ends with op_status 2.
- R6: Disable, and every undefined code (5, 6, 7), moves any stage from 0 to 4 to stage 5 without a hash request, ending with op_status 2.
- R7: Stages 5 (Disabled) and 6 (Invalid) are left only by reset. In stage 6 every operation is invalid. In stage 5 a disable succeeds and leaves the stage unchanged, and any other operation is invalid.
- R8: An advance or generate in stage 0, 5 or 6 is invalid. An invalid operation leaves the stage unchanged, ends with op_status 3 (done error) and sets err_invalid_op. The flag stays set until err_clr is pulsed.
- R9: In stages 2, 3 and 4, a generate is invalid when key_version exceeds limit 0, 1 or 2 respectively. A version equal to the limit is accepted. The limits reset to 0, 1 and 0, and lim_we bit i loads lim_wdata into limit i.
- R10: status_clr is a write-1-to-clear mask on op_status, applied only while no operation is in flight. err_clr clears err_invalid_op. When a hardware set and a clear of err_invalid_op fall in the same cycle, the set wins.
- R11: sw_bind_en is cleared by bind_we with bind_wdata 0. bind_wdata 1 has no effect. It is set back to 1 only by an advance that climbs a stage, not by an advance acting as a disable.
- R12: If hash_data is all zeros or all ones when hash_done completes an advance or generate, work_state becomes 6, fault_hash is set, and op_status is 3.
- R13: op_done is high for exactly one cycle: the first cycle in which op_status shows the result of a completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Start word write strobe |
| start_data | input | START_W | Start word; only the value 1 starts |
| op_code | input | 3 | Operation selector |
| key_version | input | VER_W | Requested key version |
| lim_we | input | 3 | Per-stage limit write enables |
| lim_wdata | input | VER_W | Limit write data |
| bind_we | input | 1 | Binding-enable write strobe |
| bind_wdata | input | 1 | Binding-enable write value (0 clears) |
| status_clr | input | 2 | Write-1-to-clear mask for op_status |
| err_clr | input | 1 | Clears err_invalid_op |
| hash_req | output | 1 | Request to the hash engine |
| hash_done | input | 1 | Hash engine completion |
| hash_data | input | DATA_W | Hash result sampled with hash_done |
| work_state | output | 3 | Current stage code |
| op_status | output | 2 | 0 idle, 1 busy, 2 success, 3 error |
| cfg_en | output | 1 | Configuration enable |
| sw_bind_en | output | 1 | Software-binding write enable |
| err_invalid_op | output | 1 | Sticky invalid-operation flag |
| fault_hash | output | 1 | Sticky fatal hash-data fault |
| op_done | output | 1 | One-cycle completion strobe |

## Verification
Completing an operation and software clearing the error flag and status can land on the same clock edge. The bench provokes this by holding err_clr and status_clr high during the exact cycle whose edge completes an invalid operation. It then expects the error flag still set and op_status reading 3, because the hardware set wins and the status mask is ignored while busy. A behavioural model in the bench tracks stage, status, flags, limits and handshake every cycle and is compared with all outputs at each falling edge.

// File: rtl/kdf_pkg.sv
package kdf_pkg;

    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_INIT      = 3'd1,
        ST_CREATOR   = 3'd2,
        ST_OWNER_INT = 3'd3,
        ST_OWNER     = 3'd4,
        ST_DISABLED  = 3'd5,
        ST_INVALID   = 3'd6
    } stage_e;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_BUSY = 2'd1,
        SS_OK   = 2'd2,
        SS_ERR  = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        K_BAD = 2'd0,
        K_DIS = 2'd1,
        K_ADV = 2'd2,
        K_GEN = 2'd3
    } kind_e;

    localparam logic [2:0] OP_ADVANCE = 3'd0;
    localparam logic [2:0] OP_DISABLE = 3'd4;

    // one version limit per key-holding stage
    localparam int unsigned NUM_LIMITS = int'(ST_OWNER) - int'(ST_CREATOR) + 1;

    function automatic logic uses_hash(kind_e k);
        return (k == K_ADV) || (k == K_GEN);
    endfunction

    function automatic int unsigned limit_reset(int unsigned idx);
        return (idx == 1) ? 1 : 0;
    endfunction

endpackage

// File: rtl/kdf_ver_limits.sv
module kdf_ver_limits
    import kdf_pkg::*;
#(
    parameter int unsigned VER_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_ok,
    input  logic [NUM_LIMITS-1:0] lim_we,
    input  logic [VER_W-1:0]      lim_wdata,
    input  stage_e                stage,
    input  logic [VER_W-1:0]      key_version,
    output logic                  ver_ok
);

    logic [VER_W-1:0] lim_q [NUM_LIMITS];

    for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim
        localparam logic [VER_W-1:0] RST_VAL = VER_W'(limit_reset(i));
        always_ff @(posedge clk) begin
            if (rst)                       lim_q[i] <= RST_VAL;
            else if (wr_ok && lim_we[i])   lim_q[i] <= lim_wdata;
        end

        AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
            !wr_ok |=> $stable(lim_q[i])); // R3
    end

    always_comb begin
        case (stage)
            ST_CREATOR:   ver_ok = (key_version <= lim_q[0]);
            ST_OWNER_INT: ver_ok = (key_version <= lim_q[1]);
            ST_OWNER:     ver_ok = (key_version <= lim_q[2]);
            default:      ver_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/kdf_op_decode.sv
module kdf_op_decode
    import kdf_pkg::*;
(
    input  stage_e     stage,
    input  logic [2:0] op_code,
    input  logic       ver_ok,
    output kind_e      kind
);

    logic [2:0] op_n;
    logic       is_adv;
    logic       is_dis;

    // undefined codes fold onto disable
    assign op_n   = (op_code > OP_DISABLE) ? OP_DISABLE : op_code;
    assign is_adv = (op_n == OP_ADVANCE);
    assign is_dis = (op_n == OP_DISABLE);

    always_comb begin
        case (stage)
            ST_RESET, ST_DISABLED:
                kind = is_dis ? K_DIS : K_BAD;
            ST_INIT, ST_CREATOR, ST_OWNER_INT, ST_OWNER: begin
                if (is_dis)
                    kind = K_DIS;
                else if (is_adv)
                    kind = (stage == ST_OWNER) ? K_DIS : K_ADV;
                else
                    kind = ver_ok ? K_GEN : K_BAD;
            end
            default:
                kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/kdf_bind_lock.sv
module kdf_bind_lock (
    input  logic clk,
    input  logic rst,
    input  logic wr_we,
    input  logic wr_data,
    input  logic hw_set,
    output logic bind_en
);

    always_ff @(posedge clk) begin
        if (rst)                      bind_en <= 1'b1;
        else if (hw_set)              bind_en <= 1'b1;
        else if (wr_we && !wr_data)   bind_en <= 1'b0;
    end

    AST_BIND_HWSET: assert property (@(posedge clk) disable iff (rst)
        hw_set |=> bind_en); // R11
    AST_BIND_ONE_NOP: assert property (@(posedge clk) disable iff (rst)
        (!hw_set && !bind_en && wr_we && wr_data) |=> !bind_en); // R11

endmodule

// File: rtl/kdf_stage_ctrl.sv
module kdf_stage_ctrl
    import kdf_pkg::*;
#(
    parameter int unsigned START_W     = 32,
    parameter int unsigned VER_W       = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned INIT_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_we,
    input  logic [START_W-1:0]    start_data,
    input  logic [2:0]            op_code,
    input  logic [VER_W-1:0]      key_version,
    input  logic [NUM_LIMITS-1:0] lim_we,
    input  logic [VER_W-1:0]      lim_wdata,
    input  logic                  bind_we,
    input  logic                  bind_wdata,
    input  logic [1:0]            status_clr,
    input  logic                  err_clr,
    output logic                  hash_req,
    input  logic                  hash_done,
    input  logic [DATA_W-1:0]     hash_data,
    output logic [2:0]            work_state,
    output logic [1:0]            op_status,
    output logic                  cfg_en,
    output logic                  sw_bind_en,
    output logic                  err_invalid_op,
    output logic                  fault_hash,
    output logic                  op_done
);

    localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    stage_e          stage_q;
    status_e         status_q;
    kind_e           kind_q;
    kind_e           kind_d;
    logic            busy_q;
    logic            err_q;
    logic            fault_q;
    logic            done_q;
    logic [CNT_W-1:0] cnt_q;
    logic            ver_ok;
    logic            start_fire;
    logic            finish;
    logic            hash_bad;
    logic            adv_ok;

    assign start_fire = !busy_q && start_we && (start_data == START_W'(1));
    assign hash_req   = busy_q && uses_hash(kind_q);
    assign finish     = busy_q && (!uses_hash(kind_q) || hash_done);
    assign hash_bad   = (hash_data == '0) || (hash_data == '1);
    assign adv_ok     = finish && (kind_q == K_ADV) && !hash_bad;

    kdf_ver_limits #(.VER_W(VER_W)) u_limits (
        .clk         (clk),
        .rst         (rst),
        .wr_ok       (!busy_q),
        .lim_we      (lim_we),
        .lim_wdata   (lim_wdata),
        .stage       (stage_q),
        .key_version (key_version),
        .ver_ok      (ver_ok)
    );

    kdf_op_decode u_decode (
        .stage   (stage_q),
        .op_code (op_code),
        .ver_ok  (ver_ok),
        .kind    (kind_d)
    );

    kdf_bind_lock u_bind (
        .clk     (clk),
        .rst     (rst),
        .wr_we   (bind_we),
        .wr_data (bind_wdata),
        .hw_set  (adv_ok),
        .bind_en (sw_bind_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= ST_RESET;
            status_q <= SS_IDLE;
            kind_q   <= K_BAD;
            busy_q   <= 1'b0;
            err_q    <= 1'b0;
            fault_q  <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            done_q <= finish;
            if (stage_q == ST_RESET && cnt_q != CNT_LAST)
                cnt_q <= cnt_q + 1'b1;

            if (start_fire) begin
                busy_q   <= 1'b1;
                kind_q   <= kind_d;
                status_q <= SS_BUSY;
            end else if (finish) begin
                busy_q <= 1'b0;
                if (kind_q == K_BAD || (uses_hash(kind_q) && hash_bad))
                    status_q <= SS_ERR;
                else
                    status_q <= SS_OK;
            end else if (!busy_q) begin
                status_q <= status_e'(status_q & ~status_clr);
            end

            if (finish && kind_q == K_BAD)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;

            if (finish && uses_hash(kind_q) && hash_bad)
                fault_q <= 1'b1;

            if (finish) begin
                case (kind_q)
                    K_DIS:   stage_q <= ST_DISABLED;
                    K_ADV:   stage_q <= hash_bad ? ST_INVALID : stage_e'(stage_q + 3'd1);
                    K_GEN:   if (hash_bad) stage_q <= ST_INVALID;
                    default: ;
                endcase
            end else if (!busy_q && !start_fire && stage_q == ST_RESET && cnt_q == CNT_LAST) begin
                stage_q <= ST_INIT;
            end
        end
    end

    assign work_state     = stage_q;
    assign op_status      = status_q;
    assign cfg_en         = !busy_q;
    assign err_invalid_op = err_q;
    assign fault_hash     = fault_q;
    assign op_done        = done_q;

    AST_START_LOCKS: assert property (@(posedge clk) disable iff (rst)
        start_fire |=> (!cfg_en && op_status == SS_BUSY)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done); // R13
    AST_INVALID_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_INVALID) |=> (stage_q == ST_INVALID)); // R7
    AST_DISABLED_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_DISABLED) |=> (stage_q == ST_DISABLED)); // R7
    AST_FAULT_IN_INVALID: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (stage_q == ST_INVALID)); // R12
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !err_clr) |=> err_q); // R8

endmodule

// File: tb/kdf_stage_ctrl_tb_top.sv
module kdf_stage_ctrl_tb_top;

    localparam int INIT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_we = 1'b0;
    logic [31:0] start_data = '0;
    logic [2:0]  op_code = '0;
    logic [31:0] key_version = '0;
    logic [2:0]  lim_we = '0;
    logic [31:0] lim_wdata = '0;
    logic        bind_we = 1'b0;
    logic        bind_wdata = 1'b0;
    logic [1:0]  status_clr = '0;
    logic        err_clr = 1'b0;
    logic        hash_done = 1'b0;
    logic [31:0] hash_data = '0;
    logic        hash_req;
    logic [2:0]  work_state;
    logic [1:0]  op_status;
    logic        cfg_en, sw_bind_en, err_invalid_op, fault_hash, op_done;

    always #2 clk = ~clk;

    kdf_stage_ctrl #(.INIT_CYCLES(INIT)) dut_i (
        .clk(clk), .rst(rst), .start_we(start_we), .start_data(start_data),
        .op_code(op_code), .key_version(key_version), .lim_we(lim_we),
        .lim_wdata(lim_wdata), .bind_we(bind_we), .bind_wdata(bind_wdata),
        .status_clr(status_clr), .err_clr(err_clr), .hash_req(hash_req),
        .hash_done(hash_done), .hash_data(hash_data), .work_state(work_state),
        .op_status(op_status), .cfg_en(cfg_en), .sw_bind_en(sw_bind_en),
        .err_invalid_op(err_invalid_op), .fault_hash(fault_hash), .op_done(op_done)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit cmp_en = 0;

    // ---------------- behavioural reference model ----------------
    int          m_stage, m_status, m_kind, m_cnt;
    bit          m_busy, m_err, m_fault, m_bind, m_done;
    logic [31:0] m_lim [3];

    function automatic int classify(int st, int op, bit vok);
        int o = (op > 4) ? 4 : op;
        if (st == 6) return 0;
        if (st == 0 || st == 5) return (o == 4) ? 1 : 0;
        if (o == 4) return 1;
        if (o == 0) return (st == 4) ? 1 : 2;
        return vok ? 3 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stage = 0; m_status = 0; m_kind = 0; m_cnt = 0;
            m_busy = 0; m_err = 0; m_fault = 0; m_bind = 1; m_done = 0;
            m_lim[0] = 0; m_lim[1] = 1; m_lim[2] = 0;
        end else begin
            bit fire, hreq, fin, bad, vok;
            int nk, nstage;
            fire = !m_busy && start_we && (start_data == 32'd1);
            hreq = m_busy && (m_kind >= 2);
            fin  = m_busy && (!hreq || hash_done);
            bad  = (hash_data == 32'h0) || (hash_data == 32'hFFFF_FFFF);
            vok  = (m_stage >= 2 && m_stage <= 4) ? (key_version <= m_lim[m_stage-2]) : 1'b1;
            nk   = classify(m_stage, op_code, vok);
            nstage = m_stage;
            m_done = fin;
            if (!m_busy)
                for (int i = 0; i < 3; i++) if (lim_we[i]) m_lim[i] = lim_wdata;
            if (fin && m_kind == 2 && !bad) m_bind = 1;
            else if (bind_we && !bind_wdata) m_bind = 0;
            if (fin && m_kind == 0) m_err = 1;
            else if (err_clr) m_err = 0;
            if (fin && m_kind >= 2 && bad) m_fault = 1;
            if (fin) begin
                if (m_kind == 1) nstage = 5;
                else if (m_kind >= 2 && bad) nstage = 6;
                else if (m_kind == 2) nstage = m_stage + 1;
            end else if (!m_busy && !fire && m_stage == 0 && m_cnt == INIT-1) begin
                nstage = 1;
            end
            if (m_stage == 0 && m_cnt != INIT-1) m_cnt++;
            if (fire) begin
                m_busy = 1; m_kind = nk; m_status = 1;
            end else if (fin) begin
                m_busy = 0;
                m_status = (m_kind == 0 || (m_kind >= 2 && bad)) ? 3 : 2;
            end else if (!m_busy) begin
                m_status = m_status & ~int'(status_clr);
            end
            m_stage = nstage;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        chk("R4 work_state vs model", int'(work_state), m_stage);
        chk("R10 op_status vs model", int'(op_status), m_status);
        chk("R3 cfg_en vs model", int'(cfg_en), int'(!m_busy));
        chk("R11 sw_bind_en vs model", int'(sw_bind_en), int'(m_bind));
        chk("R8 err_invalid_op vs model", int'(err_invalid_op), int'(m_err));
        chk("R12 fault_hash vs model", int'(fault_hash), int'(m_fault));
        chk("R13 op_done vs model", int'(op_done), int'(m_done));
        chk("R4 hash_req vs model", int'(hash_req), int'(m_busy && m_kind >= 2));
    endtask

    task automatic cyc();
        @(negedge clk);
        if (cmp_en) compare_model();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cmp_en = 1;
    endtask

    task automatic wait_init();
        for (int i = 0; i < 3*INIT && work_state != 3'd1; i++) cyc();
    endtask

    task automatic run_op(int op, int ver, int delay, logic [31:0] hd,
                          logic [2:0] blim_we, logic [31:0] blim_d, bit clr_end);
        op_code = 3'(op); key_version = ver; start_we = 1'b1; start_data = 32'd1;
        cyc();
        start_we = 1'b0;
        if (hash_req) begin
            lim_we = blim_we; lim_wdata = blim_d;
            for (int i = 0; i < delay; i++) cyc();
            lim_we = '0;
            hash_done = 1'b1; hash_data = hd;
        end
        if (clr_end) begin err_clr = 1'b1; status_clr = 2'b11; end
        cyc();
        hash_done = 1'b0; err_clr = 1'b0; status_clr = 2'b00;
        chk("R13 op_done after completion", int'(op_done), 1);
        cyc();
        chk("R13 op_done low next cycle", int'(op_done), 0);
    endtask

    task automatic clear_all();
        err_clr = 1'b1; status_clr = 2'b11;
        cyc();
        err_clr = 1'b0; status_clr = 2'b00;
    endtask

    localparam logic [31:0] GOOD = 32'h1234_5678;

    initial begin
        do_reset();
        cyc();
        chk("R1 reset stage", int'(work_state), 0);
        chk("R1 reset status", int'(op_status), 0);
        chk("R1 reset cfg_en", int'(cfg_en), 1);
        chk("R1 reset bind", int'(sw_bind_en), 1);
        chk("R1 reset hash_req", int'(hash_req), 0);

        // start word other than 1 does nothing
        start_we = 1'b1; start_data = 32'd2; op_code = 3'd4;
        cyc();
        start_we = 1'b0;
        cyc();
        chk("R2 non-one start ignored cfg_en", int'(cfg_en), 1);
        chk("R2 non-one start ignored stage", int'(work_state), 0);

        // advance while still in Reset is invalid
        run_op(0, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R8 advance in Reset err", int'(err_invalid_op), 1);
        chk("R8 advance in Reset status", int'(op_status), 3);
        chk("R8 advance in Reset stage", int'(work_state), 0);
        wait_init();
        chk("R1 init reached", int'(work_state), 1);
        clear_all();
        chk("R10 status cleared", int'(op_status), 0);
        chk("R10 err cleared", int'(err_invalid_op), 0);

        // generate in Init
        run_op(1, 0, 2, GOOD, 3'b000, 0, 0);
        chk("R4 generate ok status", int'(op_status), 2);
        chk("R4 generate keeps stage", int'(work_state), 1);

        // limits: set limit0 = 5 while idle
        lim_we = 3'b001; lim_wdata = 32'd5;
        cyc();
        lim_we = '0;

        // lock binding then advance; busy limit write to limit1 ignored
        bind_we = 1'b1; bind_wdata = 1'b0;
        cyc();
        bind_we = 1'b0;
        cyc();
        chk("R11 bind cleared by 0", int'(sw_bind_en), 0);
        bind_we = 1'b1; bind_wdata = 1'b1;
        cyc();
        bind_we = 1'b0;
        cyc();
        chk("R11 write 1 no effect", int'(sw_bind_en), 0);
        run_op(0, 0, 3, GOOD, 3'b010, 32'd0, 0);
        chk("R4 advance to creator", int'(work_state), 2);
        chk("R11 bind set by advance", int'(sw_bind_en), 1);

        run_op(2, 6, 1, GOOD, 3'b000, 0, 0);
        chk("R9 version above limit", int'(op_status), 3);
        run_op(3, 5, 1, GOOD, 3'b000, 0, 0);
        chk("R9 version equal limit", int'(op_status), 2);

        run_op(0, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R4 advance to owner int", int'(work_state), 3);
        run_op(2, 1, 2, GOOD, 3'b000, 0, 0);
        chk("R3 busy limit write ignored", int'(op_status), 2);
        run_op(2, 2, 2, GOOD, 3'b000, 0, 0);
        chk("R9 limit1 exceeded", int'(op_status), 3);

        // invalid op completing while err_clr and status_clr are high
        run_op(1, 9, 0, GOOD, 3'b000, 0, 1);
        chk("R10 set wins over clear", int'(err_invalid_op), 1);
        chk("R10 status clear ignored while busy", int'(op_status), 3);
        clear_all();

        run_op(0, 0, 1, GOOD, 3'b000, 0, 0);
        chk("R4 advance to owner", int'(work_state), 4);
        bind_we = 1'b1; bind_wdata = 1'b0;
        cyc();
        bind_we = 1'b0;
        run_op(0, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R5 advance at owner disables", int'(work_state), 5);
        chk("R5 status ok", int'(op_status), 2);
        chk("R11 no bind set on disable-advance", int'(sw_bind_en), 0);

        run_op(4, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R7 disable in Disabled ok", int'(op_status), 2);
        chk("R7 stays Disabled", int'(work_state), 5);
        run_op(3, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R7 generate in Disabled err", int'(op_status), 3);
        chk("R8 stage held", int'(work_state), 5);

        // undefined codes act as disable
        do_reset(); wait_init();
        run_op(0, 0, 1, GOOD, 3'b000, 0, 0);
        run_op(6, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R6 code 6 disables", int'(work_state), 5);
        do_reset(); wait_init();
        run_op(5, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R6 code 5 disables", int'(work_state), 5);
        chk("R6 status ok", int'(op_status), 2);

        // bad hash data
        do_reset(); wait_init();
        run_op(0, 0, 2, 32'h0, 3'b000, 0, 0);
        chk("R12 all-zero invalid", int'(work_state), 6);
        chk("R12 fault set", int'(fault_hash), 1);
        chk("R12 status error", int'(op_status), 3);
        run_op(4, 0, 0, GOOD, 3'b000, 0, 0);
        chk("R7 Invalid stays", int'(work_state), 6);
        chk("R7 disable in Invalid err", int'(err_invalid_op), 1);
        do_reset(); wait_init();
        run_op(0, 0, 0, GOOD, 3'b000, 0, 0);
        run_op(1, 0, 1, 32'hFFFF_FFFF, 3'b000, 0, 0);
        chk("R12 all-one invalid", int'(work_state), 6);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule